// File: doc/BRIEF.md
# First-Error ECC Address Capture

This block sits beside a memory's ECC decoder and keeps a record of the faults it reports. There are two error kinds: single-bit errors that the decoder corrected, and double-bit errors that it could only detect. Each kind has a sticky flag and a register that holds the system bus address of the read that first raised that flag. Once a flag is set, later errors of the same kind leave both the flag and the stored address unchanged. Software can therefore always see where the first fault happened.

Software acknowledges a fault with a one-cycle clear strobe for that kind. The strobe drops the flag and resets the captured address to zero, so the slot is ready for the next error. A single interrupt line combines the two flags, each gated by its own enable input. The ECC encoding and decoding are outside this block. Its inputs are the per-read error pulses and the address of the read.

Top module: `ecc_fault_capture`

## Requirements
- R1: After reset, both flags are 0, both captured addresses are 0 and `irq_o` is 0.
- R2: A single-error pulse (`sec_err_i`=1 at a rising edge) with `sec_flag_o`=0 and `sec_clr_i`=0 sets `sec_flag_o` after that edge and loads `rd_addr_i` into `sec_addr_o`.
- R3: A double-error pulse is captured in the same way into `ded_flag_o`/`ded_addr_o`. It never changes the single-error flag or address.
- R4: While a flag is set and no clear strobe for that kind is present, further errors of that kind change neither the flag nor the captured address.
- R5: A clear strobe for a kind drives that flag to 0 and that captured address to 0 after the edge. The other kind is not affected.
- R6: When an error pulse and the clear strobe of the same kind meet at one edge, the clear wins: afterwards the flag is 0 and the address is 0.
- R7: `irq_o` = (`sec_flag_o` AND `sec_irq_en_i`) OR (`ded_flag_o` AND `ded_irq_en_i`). It follows the enable inputs combinationally.
- R8: A captured address is 0 whenever its flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_err_i | input | 1 | Single-bit corrected error on the current read |
| ded_err_i | input | 1 | Double-bit detected error on the current read |
| rd_addr_i | input | 32 | System bus address of the current read |
| sec_clr_i | input | 1 | Clear strobe for the single-error flag and address |
| ded_clr_i | input | 1 | Clear strobe for the double-error flag and address |
| sec_irq_en_i | input | 1 | Interrupt enable for the single-error flag |
| ded_irq_en_i | input | 1 | Interrupt enable for the double-error flag |
| sec_flag_o | output | 1 | Sticky single-error flag |
| ded_flag_o | output | 1 | Sticky double-error flag |
| sec_addr_o | output | 32 | First single-error address, 0 when the flag is clear |
| ded_addr_o | output | 32 | First double-error address, 0 when the flag is clear |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the error pulses, the clear strobes and the read address are synchronous to `clk_i` and hold a defined 0 or 1 at every sampled edge after reset. They also assume that the address is meaningful only in cycles where an error pulse is high. The bench changes every input only at the falling edge, so no input moves near the sampling edge. It draws the error and clear pulses at random with moderate probability, so that errors often land on a set flag and sometimes coincide with a clear. Random addresses make any overwrite of a held address visible.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  localparam int KINDS = 2;

  typedef enum int {
    KIND_SEC = 0,
    KIND_DED = 1
  } err_kind_e;

  // An error is taken only into an empty slot, and never against a clear.
  function automatic logic take_error(input logic err, input logic flag, input logic clr);
    return err && !flag && !clr;
  endfunction

  // Next value of a sticky flag: a clear dominates, otherwise set-and-hold.
  function automatic logic next_flag(input logic err, input logic flag, input logic clr);
    return clr ? 1'b0 : (flag | err);
  endfunction

  // Combined interrupt over all kinds.
  function automatic logic irq_merge(input logic [KINDS-1:0] flags,
                                     input logic [KINDS-1:0] en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/ecc_cap_slot.sv
module ecc_cap_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  import ecc_cap_pkg::*;

  logic capture_ev;
  logic clear_ev;
  logic drop_ev;
  logic flag_d;

  assign capture_ev = take_error(err_i, flag_o, clr_i);
  assign clear_ev   = clr_i;
  assign drop_ev    = err_i && (flag_o || clr_i);
  assign flag_d     = next_flag(err_i, flag_o, clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end else begin
      flag_o <= flag_d;
      if (clear_ev) begin
        addr_o <= '0;
      end else if (capture_ev) begin
        addr_o <= addr_i;
      end
    end
  end

  // R2/R3: first error of this kind is latched with its address
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_ev |=> (flag_o && addr_o == $past(addr_i)));

  // R4: held slot keeps its flag and address
  a_r4_first_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> (flag_o && $stable(addr_o)));

  // R5: clear empties the slot
  a_r5_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_ev |=> (!flag_o && addr_o == '0));

  // R6: a dropped error never leaves the slot newly set
  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_ev && clr_i) |=> !flag_o);

  // R8: empty slot reads as address zero
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |-> (addr_o == '0));

endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq (
  input  logic [ecc_cap_pkg::KINDS-1:0] flags_i,
  input  logic [ecc_cap_pkg::KINDS-1:0] en_i,
  output logic                          irq_o
);
  import ecc_cap_pkg::*;

  always_comb begin
    irq_o = irq_merge(flags_i, en_i);
  end

endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_err_i,
  input  logic              ded_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              sec_clr_i,
  input  logic              ded_clr_i,
  input  logic              sec_irq_en_i,
  input  logic              ded_irq_en_i,
  output logic              sec_flag_o,
  output logic              ded_flag_o,
  output logic [ADDR_W-1:0] sec_addr_o,
  output logic [ADDR_W-1:0] ded_addr_o,
  output logic              irq_o
);
  import ecc_cap_pkg::*;

  logic [KINDS-1:0] err_v;
  logic [KINDS-1:0] clr_v;
  logic [KINDS-1:0] en_v;
  logic [KINDS-1:0] flag_v;
  logic [ADDR_W-1:0] addr_a [KINDS];

  assign err_v[KIND_SEC] = sec_err_i;
  assign err_v[KIND_DED] = ded_err_i;
  assign clr_v[KIND_SEC] = sec_clr_i;
  assign clr_v[KIND_DED] = ded_clr_i;
  assign en_v[KIND_SEC]  = sec_irq_en_i;
  assign en_v[KIND_DED]  = ded_irq_en_i;

  for (genvar k = 0; k < KINDS; k++) begin : g_slot
    ecc_cap_slot #(
      .ADDR_W(ADDR_W)
    ) slot_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .err_i  (err_v[k]),
      .addr_i (rd_addr_i),
      .clr_i  (clr_v[k]),
      .flag_o (flag_v[k]),
      .addr_o (addr_a[k])
    );
  end

  ecc_cap_irq irq_i (
    .flags_i (flag_v),
    .en_i    (en_v),
    .irq_o   (irq_o)
  );

  assign sec_flag_o = flag_v[KIND_SEC];
  assign ded_flag_o = flag_v[KIND_DED];
  assign sec_addr_o = addr_a[KIND_SEC];
  assign ded_addr_o = addr_a[KIND_DED];

  // R7: an enabled, set flag raises the interrupt
  a_r7_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sec_flag_o && sec_irq_en_i) || (ded_flag_o && ded_irq_en_i)) |-> irq_o);

  // R7: no enabled flag means no interrupt
  a_r7_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sec_flag_o && sec_irq_en_i) && !(ded_flag_o && ded_irq_en_i)) |-> !irq_o);

  // R3: a double-error edge alone leaves the single-error slot untouched
  a_r3_kinds_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_err_i && !sec_clr_i) |=> ($stable(sec_flag_o) && $stable(sec_addr_o)));

endmodule

// File: tb/ecc_fault_capture_tb.sv
`timescale 1ns/1ps
module ecc_fault_capture_tb_top;

  logic        clk;
  logic        rst_n;
  logic        sec_err, ded_err, sec_clr, ded_clr, sec_en, ded_en;
  logic [31:0] addr;
  logic        sec_flag, ded_flag, irq;
  logic [31:0] sec_addr, ded_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  logic        m_flag [2];
  logic [31:0] m_addr [2];

  ecc_fault_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sec_err_i(sec_err), .ded_err_i(ded_err), .rd_addr_i(addr),
    .sec_clr_i(sec_clr), .ded_clr_i(ded_clr),
    .sec_irq_en_i(sec_en), .ded_irq_en_i(ded_en),
    .sec_flag_o(sec_flag), .ded_flag_o(ded_flag),
    .sec_addr_o(sec_addr), .ded_addr_o(ded_addr), .irq_o(irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic exp_irq(input logic f0, input logic e0,
                                   input logic f1, input logic e1);
    if (f0 && e0) return 1'b1;
    if (f1 && e1) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // advance the model by one rising edge using the currently driven inputs
  task automatic model_step();
    logic e [2];
    logic c [2];
    e[0] = sec_err; e[1] = ded_err;
    c[0] = sec_clr; c[1] = ded_clr;
    for (int k = 0; k < 2; k++) begin
      if (c[k]) begin
        m_flag[k] = 1'b0;
        m_addr[k] = 32'h0;
      end else if (e[k] && !m_flag[k]) begin
        m_flag[k] = 1'b1;
        m_addr[k] = addr;
      end
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "sec_flag", {31'b0, sec_flag}, {31'b0, m_flag[0]});
    chk(req, "sec_addr", sec_addr, m_addr[0]);
    chk(req, "ded_flag", {31'b0, ded_flag}, {31'b0, m_flag[1]});
    chk(req, "ded_addr", ded_addr, m_addr[1]);
  endtask

  // drive inputs at a falling edge, step model, wait for the next falling edge
  task automatic cycle(input logic se, input logic de, input logic [31:0] a,
                       input logic sc, input logic dc);
    sec_err = se; ded_err = de; addr = a; sec_clr = sc; ded_clr = dc;
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    sec_err = 0; ded_err = 0; sec_clr = 0; ded_clr = 0;
    sec_en = 1; ded_en = 1; addr = 0;
    for (int k = 0; k < 2; k++) begin
      m_flag[k] = 0;
      m_addr[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check_state("R1");
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2: single-error capture
    cycle(1'b1, 1'b0, 32'h0800_1240, 1'b0, 1'b0);
    check_state("R2");
    chk("R2", "sec_addr", sec_addr, 32'h0800_1240);
    // R3: double-error goes to its own slot, single slot untouched
    cycle(1'b0, 1'b1, 32'h0810_0080, 1'b0, 1'b0);
    check_state("R3");
    chk("R3", "ded_addr", ded_addr, 32'h0810_0080);
    chk("R3", "sec_addr kept", sec_addr, 32'h0800_1240);
    // R4: later errors do not overwrite
    cycle(1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    chk("R4", "sec_addr kept", sec_addr, 32'h0800_1240);
    chk("R4", "ded_addr kept", ded_addr, 32'h0810_0080);
    // R7: interrupt follows enables combinationally
    sec_en = 0; ded_en = 0; #1;
    chk("R7", "irq all disabled", {31'b0, irq}, 32'h0);
    ded_en = 1; #1;
    chk("R7", "irq ded enabled", {31'b0, irq}, 32'h1);
    @(negedge clk);
    // R5: clear single only, double kept
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R5", "sec_flag cleared", {31'b0, sec_flag}, 32'h0);
    chk("R5", "sec_addr wiped", sec_addr, 32'h0);
    chk("R5", "ded_addr kept", ded_addr, 32'h0810_0080);
    sec_en = 1; #1;
    chk("R7", "irq only ded set", {31'b0, irq}, 32'h1);
    // R6: clear and error at the same edge on the double slot, and on an empty sec slot
    cycle(1'b1, 1'b1, 32'h1234_5678, 1'b1, 1'b1);
    chk("R6", "sec_flag", {31'b0, sec_flag}, 32'h0);
    chk("R6", "ded_flag", {31'b0, ded_flag}, 32'h0);
    chk("R6", "ded_addr", ded_addr, 32'h0);
    // R8: empty slots read zero
    chk("R8", "sec_addr", sec_addr, 32'h0);
    #1;
    chk("R7", "irq none set", {31'b0, irq}, 32'h0);
    // R2: recapture after clear with a fresh address
    cycle(1'b1, 1'b0, 32'hFFFF_FFC0, 1'b0, 1'b0);
    chk("R2", "sec_addr new", sec_addr, 32'hFFFF_FFC0);
    idle();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic se, de, sc, dc;
      se = ($urandom % 4) == 0;
      de = ($urandom % 5) == 0;
      sc = ($urandom % 8) == 0;
      dc = ($urandom % 8) == 0;
      sec_en = $urandom % 2;
      ded_en = $urandom % 2;
      #1;
      chk("R7", "irq random", {31'b0, irq},
          {31'b0, exp_irq(m_flag[0], sec_en, m_flag[1], ded_en)});
      cycle(se, de, $urandom, sc, dc);
      chk("R4", "sec_flag", {31'b0, sec_flag}, {31'b0, m_flag[0]});
      chk("R4", "sec_addr", sec_addr, m_addr[0]);
      chk("R3", "ded_flag", {31'b0, ded_flag}, {31'b0, m_flag[1]});
      chk("R3", "ded_addr", ded_addr, m_addr[1]);
      if (!sec_flag) chk("R8", "sec_addr empty", sec_addr, 32'h0);
      if (!ded_flag) chk("R8", "ded_addr empty", ded_addr, 32'h0);
    end
    summary();
  end

endmodule